// File: doc/BRIEF.md
# Double-Indexed Byte Address Sequencer

This block produces the byte address sequence for one block transfer of a DMA channel. The transfer is organised at three levels: bytes, elements (1, 2 or 4 bytes) and frames (a whole number of elements). Inside an element, addresses climb by one. Crossing into a new element adds a signed element offset instead. Crossing into a new frame adds a signed frame offset, and this rule takes precedence over the element offset.

Software sets the start address, the block length in bytes, an element-size code, the number of elements per frame and the two offsets, then pulses `start`. The sequencer presents one address at a time with `vld`. Each address comes with its byte index, element-start and frame-start markers, and a `last` flag. It advances on every `vld && rdy` handshake. Element and frame boundaries are found with reloading down-counters, so no divider is needed. After the final byte is accepted, `done` pulses for one cycle.

Top module: `dix_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `vld` and `done` are low.
- R2: A `start` pulse while idle with a non-zero length makes `vld` high in the next cycle, with `addr` equal to the start address, `idx` 0, and both `elem_first` and `frame_first` high.
- R3: On acceptance of byte i−1, if byte i starts neither an element nor a frame, the next address is the previous address plus 1 and `idx` increases by 1. Both markers are low.
- R4: If byte i starts an element but not a frame (i a multiple of the element size only), the next address is the previous address plus the element offset. The offset is a 16-bit two's complement value, sign-extended. `elem_first` is high.
- R5: If byte i starts a frame (i a multiple of frame size = element size × element count), the next address is the previous address plus the sign-extended 16-bit frame offset. The element offset is not applied. Both markers are high.
- R6: Element-size code `cfg_esz`: 0 selects 1 byte, 1 selects 2 bytes, 2 and 3 select 4 bytes.
- R7: While `vld` is high and `rdy` is low, `vld`, `addr`, `idx` and both markers hold their values.
- R8: `last` is high exactly with byte index length−1. The cycle after that byte is accepted, `vld` is low and `done` is high for that one cycle only.
- R9: A `start` pulse while `vld` is high is ignored. The running sequence continues unchanged, and no extra bytes follow it.
- R10: A `start` pulse with length 0 raises `done` in the next cycle and never raises `vld`.
- R11: Address arithmetic wraps modulo 2^24.
- R12: An element count of 0 behaves as an element count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer with the current configuration |
| cfg_sa | input | 24 | Start address |
| cfg_len | input | 16 | Block length in bytes |
| cfg_esz | input | 2 | Element-size code |
| cfg_ecnt | input | 16 | Elements per frame |
| cfg_eidx | input | 16 | Signed element offset |
| cfg_fidx | input | 16 | Signed frame offset |
| rdy | input | 1 | Consumer accepts the current address |
| vld | output | 1 | Address valid |
| addr | output | 24 | Current byte address |
| idx | output | 16 | Current byte index |
| last | output | 1 | Current byte is the final one |
| elem_first | output | 1 | Current byte starts an element |
| frame_first | output | 1 | Current byte starts a frame |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several rules are checked by the assertions on every cycle. Outputs must hold during back-pressure, and the index must advance by one per accepted byte. Completion must follow the last byte, `done` must stay a single pulse, a frame start must also be an element start, and index 0 must carry both markers. The bench's scenarios are the only check on the address values themselves. They compare each accepted address against a model written from the recurrence, using all four element-size codes, negative and extreme offsets, a wrap across 2^24, a zero element count, lengths of 0 and 1, and a start pulse during a busy transfer.

// File: rtl/dix_addr_gen.sv
module dix_addr_gen #(
  parameter int AW = 24,
  parameter int LW = 16,
  parameter int CW = 16,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_sa,
  input  logic [LW-1:0] cfg_len,
  input  logic [1:0]    cfg_esz,
  input  logic [CW-1:0] cfg_ecnt,
  input  logic [OW-1:0] cfg_eidx,
  input  logic [OW-1:0] cfg_fidx,
  input  logic          rdy,
  output logic          vld,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] idx,
  output logic          last,
  output logic          elem_first,
  output logic          frame_first,
  output logic          done
);
  localparam int FW = CW + 3;

  logic [LW-1:0] len_m1;
  logic [1:0]    es_m1, e_rem;
  logic [FW-1:0] fs_m1, f_rem;
  logic [AW-1:0] ei_x, fi_x;

  logic [1:0]    sh;
  logic [CW-1:0] en_eff;
  logic [FW-1:0] fs_new;

  assign sh     = (cfg_esz == 2'd0) ? 2'd0 : (cfg_esz == 2'd1) ? 2'd1 : 2'd2;
  assign en_eff = (cfg_ecnt == '0) ? CW'(1) : cfg_ecnt;
  assign fs_new = FW'(en_eff) << sh;

  assign last = vld && (idx == len_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld         <= 1'b0;
      done        <= 1'b0;
      addr        <= '0;
      idx         <= '0;
      len_m1      <= '0;
      es_m1       <= '0;
      e_rem       <= '0;
      fs_m1       <= '0;
      f_rem       <= '0;
      ei_x        <= '0;
      fi_x        <= '0;
      elem_first  <= 1'b0;
      frame_first <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !vld) begin
        if (cfg_len == '0) begin
          done <= 1'b1;
        end else begin
          vld         <= 1'b1;
          addr        <= cfg_sa;
          idx         <= '0;
          len_m1      <= cfg_len - 1'b1;
          es_m1       <= 2'((3'd1 << sh) - 3'd1);
          e_rem       <= 2'((3'd1 << sh) - 3'd1);
          fs_m1       <= fs_new - 1'b1;
          f_rem       <= fs_new - 1'b1;
          ei_x        <= {{(AW-OW){cfg_eidx[OW-1]}}, cfg_eidx};
          fi_x        <= {{(AW-OW){cfg_fidx[OW-1]}}, cfg_fidx};
          elem_first  <= 1'b1;
          frame_first <= 1'b1;
        end
      end else if (vld && rdy) begin
        if (last) begin
          vld  <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          if (f_rem == '0) begin
            addr        <= addr + fi_x;
            f_rem       <= fs_m1;
            e_rem       <= es_m1;
            elem_first  <= 1'b1;
            frame_first <= 1'b1;
          end else if (e_rem == '0) begin
            addr        <= addr + ei_x;
            f_rem       <= f_rem - 1'b1;
            e_rem       <= es_m1;
            elem_first  <= 1'b1;
            frame_first <= 1'b0;
          end else begin
            addr        <= addr + 1'b1;
            f_rem       <= f_rem - 1'b1;
            e_rem       <= e_rem - 1'b1;
            elem_first  <= 1'b0;
            frame_first <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module dix_addr_gen_chk #(
  parameter int AW = 24,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rdy,
  input logic          vld,
  input logic [AW-1:0] addr,
  input logic [LW-1:0] idx,
  input logic          last,
  input logic          elem_first,
  input logic          frame_first,
  input logic          done
);
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !rdy |=> vld && $stable(addr) && $stable(idx) && $stable(elem_first) && $stable(frame_first));

  a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    vld && rdy && !last |=> vld && (idx == LW'($past(idx) + 1'b1)));

  a_r8_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    vld && rdy && last |=> done && !vld);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  a_r5_frame_is_elem: assert property (@(posedge clk) disable iff (!rst_n)
    vld && frame_first |-> elem_first);

  a_r2_first_markers: assert property (@(posedge clk) disable iff (!rst_n)
    vld && (idx == '0) |-> elem_first && frame_first);

  a_r9_busy_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    vld && start && !(rdy && last) |=> vld);
endmodule

bind dix_addr_gen dix_addr_gen_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rdy(rdy), .vld(vld), .addr(addr),
  .idx(idx), .last(last), .elem_first(elem_first), .frame_first(frame_first), .done(done)
);

// File: tb/tb_dix_addr_gen.sv
`timescale 1ns/1ps
module tb_dix_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] cfg_sa = '0;
  logic [15:0] cfg_len = '0;
  logic [1:0]  cfg_esz = '0;
  logic [15:0] cfg_ecnt = '0;
  logic [15:0] cfg_eidx = '0;
  logic [15:0] cfg_fidx = '0;
  logic        rdy = 1'b0;
  logic        vld, last, elem_first, frame_first, done;
  logic [23:0] addr;
  logic [15:0] idx;

  int total = 0;
  int bad = 0;
  bit stall_en = 1'b0;

  typedef struct {
    logic [23:0] a;
    int          i;
    bit          ef;
    bit          ff;
    bit          lst;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  dix_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_sa(cfg_sa), .cfg_len(cfg_len),
    .cfg_esz(cfg_esz), .cfg_ecnt(cfg_ecnt), .cfg_eidx(cfg_eidx), .cfg_fidx(cfg_fidx),
    .rdy(rdy), .vld(vld), .addr(addr), .idx(idx), .last(last),
    .elem_first(elem_first), .frame_first(frame_first), .done(done)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  initial begin : ready_drv
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  // scoreboard monitor: R2 R3 R4 R5 R7
  bit          p_stall = 1'b0;
  logic [23:0] p_addr;
  logic [15:0] p_idx;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_stall)
        check(vld && addr == p_addr && idx == p_idx, "R7 hold during stall", {vld, addr}, {1'b1, p_addr});
      p_stall = vld && !rdy;
      p_addr  = addr;
      p_idx   = idx;
      if (vld && rdy) begin
        if (q.size() == 0) begin
          check(1'b0, "R9 unexpected byte", idx, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(addr == e.a, {e.tag, " addr"}, addr, e.a);
          check(int'(idx) == e.i && elem_first == e.ef && frame_first == e.ff && last == e.lst,
                {e.tag, " idx/markers/last"}, {idx, elem_first, frame_first, last},
                {e.i[15:0], e.ef, e.ff, e.lst});
        end
      end
    end
  end

  task automatic xfer(input logic [23:0] sa, input int bs, input logic [1:0] esz, input int en,
                      input logic [15:0] ei, input logic [15:0] fi, input bit poke, input string note);
    int es, fs;
    logic [23:0] a;
    bit seen;
    es = (esz == 0) ? 1 : (esz == 1) ? 2 : 4;   // R6
    fs = es * ((en == 0) ? 1 : en);             // R12
    a  = sa;
    for (int i = 0; i < bs; i++) begin
      exp_t e;
      string t;
      if (i == 0) t = "R2";
      else if (i % fs == 0) begin a = a + 24'(signed'(fi)); t = "R5"; end
      else if (i % es == 0) begin a = a + 24'(signed'(ei)); t = "R4"; end
      else begin a = a + 24'd1; t = "R3"; end
      e.a = a; e.i = i; e.ef = (i % es == 0); e.ff = (i % fs == 0);
      e.lst = (i == bs - 1); e.tag = {t, " ", note};
      q.push_back(e);
    end
    @(posedge clk); #1;
    cfg_sa = sa; cfg_len = 16'(bs); cfg_esz = esz; cfg_ecnt = 16'(en);
    cfg_eidx = ei; cfg_fidx = fi; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      cfg_sa = 24'h0; cfg_len = 16'd3; cfg_esz = 2'd0; cfg_ecnt = 16'd1; start = 1'b1;  // R9
      @(posedge clk); #1;
      start = 1'b0;
    end
    seen = 1'b0;
    for (int c = 0; c < 4000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(seen && !vld, {"R8 done with vld low ", note}, {seen, vld}, 2'b10);
    check(q.size() == 0, {"R8 all bytes before done ", note}, q.size(), 0);
    q.delete();
    @(negedge clk);
    check(!done, {"R8 done one cycle ", note}, done, 0);
    repeat (4) @(negedge clk);
    check(!vld && !done, {"R9 nothing after done ", note}, {vld, done}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!vld && !done, "R1 state in reset", {vld, done}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!vld && !done, "R1 state after reset", {vld, done}, 0);

    stall_en = 1'b0;
    xfer(24'h001000, 12, 2'd0, 4, 16'h0010, 16'h0100, 1'b0, "es1");
    stall_en = 1'b1;
    xfer(24'h200000, 20, 2'd1, 3, 16'hFFFC, 16'h8000, 1'b0, "es2 negative");
    xfer(24'hFFFFF8, 17, 2'd2, 2, 16'h0003, 16'h0007, 1'b0, "R6 es4 R11 wrap");
    xfer(24'h000040, 9, 2'd3, 0, 16'h1111, 16'h7FFF, 1'b0, "R6 code3 R12 en0");
    xfer(24'h123456, 30, 2'd1, 2, 16'h0020, 16'hFF00, 1'b1, "R9 busy start");
    stall_en = 1'b0;
    xfer(24'h000abc, 1, 2'd2, 5, 16'h0001, 16'h0001, 1'b0, "len1");
    xfer(24'h000abc, 0, 2'd0, 1, 16'h0001, 16'h0001, 1'b0, "R10 len0");
    xfer(24'h000010, 8, 2'd0, 1, 16'h0005, 16'hFFFF, 1'b0, "R5 frame equals element");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule